// File: doc/BRIEF.md
# Programmable LED Pattern Sequencer

This block is one brightness channel of a multi-colour indicator driver. It keeps up to sixteen 16-bit commands in a small local store. It interprets them one at a time, paced by a slow timing tick (nominally 32 kHz), and produces an 8-bit brightness value. A PWM stage outside the block consumes that value. The commands cover:

- timed ramps up or down, and plain waits
- immediate brightness settings
- trigger pulses to, and trigger waits on, sibling channels
- counted loops
- a stop command

The host controls the channel through a 2-bit mode and a 2-bit execution control. It can also write the program store and the program counter. In direct mode the channel bypasses the interpreter and passes a host brightness straight through.

Mode changes, execution-control writes and program-counter writes are all held until the next tick and take effect there. This keeps every change of interpreter state aligned to the tick domain.

Top module: `ledSeqEngine`

## Requirements
- R1: After reset the brightness output is 0, the program counter is 0, no trigger line is driven, the mode is disabled (code 11) and execution control is hold.
- R2: While the applied mode is disabled (code 11), the brightness output is 0. The program counter is forced to 0 on every tick.
- R3: While the applied mode is direct (code 00), the brightness output equals `directPwm` at once, with no tick needed. The interpreter does nothing in this mode.
- R4: A command-store write (`memWrEn`) takes effect only while the applied mode is load (code 01). In any other mode the write is ignored and the stored command is unchanged. Execution is halted in load mode.
- R5: A command with bit 15 = 0 and a non-zero step field is a ramp, laid out as follows:
  - bit 14 is the prescale (0 gives 16 ticks per unit, 1 gives 512 ticks per unit)
  - bits 13:8 are the step field S
  - bit 7 is the sign (0 counts up)
  - bits 6:0 are the increment count N
  
  Taking the decode tick as tick 0, the k-th change of ±1 happens at tick k·S·unit. Brightness saturates at 0 and 255. The program counter advances together with the last change. When N = 0 the command is a wait of one S·unit period with no change.
- R6: A command with bit 15 = 0 and step field 0 loads bits 7:0 into the brightness on its decode tick and advances the program counter.
- R7: A trigger command (bits 15:13 = 101) with a non-zero send mask in bits 5:0 drives that mask on `trigOut`. The mask is held for exactly 16 ticks starting at the decode tick, and is then dropped. If the command's wait mask is zero, the program counter advances on the tick that drops the mask.
- R8: A trigger command whose wait mask (bits 11:6) is non-zero stalls the program. The stall ends on the tick by which every masked `trigIn` line has been seen high at some tick after the wait began. Lines may arrive on different ticks.
- R9: `modeIn` is applied on the next tick. A pending execution-control write or program-counter write is also applied on the next tick. Between ticks the program counter and `trigOut` never change.
- R10: Execution-control codes are applied as follows:
  - 00 hold: the interpreter stops.
  - 01 step: one command runs to completion, then control returns to hold.
  - 10 run-from-start: the program counter is cleared when the code is applied, then commands run continuously.
  - 11 run-from-current: commands run continuously from the present counter.
- R11: A branch command (bits 15:13 = 110) carries a loop count L in bits 9:4 and a target in bits 3:0. It jumps to the target L times in a row. On the next encounter it falls through to the next address and re-arms the loop.
- R12: An end command (bits 15:13 = 100) sets execution control to hold. It clears the program counter when bit 12 is 1 and leaves it in place otherwise. After an end, no further command executes.
- R13: The program counter is 4 bits wide and wraps from 15 to 0 when it advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle timing tick (32 kHz rate) |
| modeIn | input | 2 | Channel mode: 00 direct, 01 load, 10 run, 11 disabled |
| execWr | input | 1 | Strobe that queues `execIn` for the next tick |
| execIn | input | 2 | Execution control: 00 hold, 01 step, 10 run-from-start, 11 run-from-current |
| memWrEn | input | 1 | Command-store write strobe (load mode only) |
| memAddr | input | 4 | Command-store write address |
| memData | input | 16 | Command word to store |
| pcWrEn | input | 1 | Strobe that queues `pcWrData` for the next tick |
| pcWrData | input | 4 | New program counter value |
| directPwm | input | 8 | Host brightness used in direct mode |
| trigIn | input | TRIG_N | Trigger lines from sibling channels |
| brightOut | output | 8 | Channel brightness |
| pcOut | output | 4 | Current program counter |
| trigOut | output | TRIG_N | Trigger lines to sibling channels |

## Verification
Most wrong interpreter states become visible at `pcOut` within one tick, because every command advances or holds the counter on a known tick. A broken ramp counter shows up as a brightness change one tick early or late, so the bench samples on both sides of each expected step boundary. A wrong loop or end state can only be seen many ticks later. For that reason, the outputs are also checked after the program should have halted, to catch execution that keeps running. Trigger faults show as `trigOut` held for the wrong number of ticks, or as a wait that ends before every masked line has arrived.

// File: rtl/ledSeqPkg.sv
`timescale 1ns/1ps
package ledSeqPkg;
  localparam int CMD_W     = 16;
  localparam int CMD_DEPTH = 16;
  localparam int PC_W      = $clog2(CMD_DEPTH);
  localparam int BR_W      = 8;
  localparam int MASK_W    = 6;

  typedef enum logic [1:0] {
    MODE_DIRECT = 2'b00,
    MODE_LOAD   = 2'b01,
    MODE_RUN    = 2'b10,
    MODE_OFF    = 2'b11
  } modeT;

  typedef enum logic [1:0] {
    EX_HOLD   = 2'b00,
    EX_STEP   = 2'b01,
    EX_RUN0   = 2'b10,
    EX_RUNCUR = 2'b11
  } execT;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RAMP = 2'b01,
    ST_SEND = 2'b10,
    ST_WAIT = 2'b11
  } stateT;

  localparam logic [1:0] OP_END    = 2'b00;
  localparam logic [1:0] OP_TRIG   = 2'b01;
  localparam logic [1:0] OP_BRANCH = 2'b10;
  localparam logic [1:0] OP_NOP    = 2'b11;

  // strobes from the interpreter to the datapath, valid for one cycle
  typedef struct packed {
    logic              pcInc;
    logic              pcJump;
    logic [PC_W-1:0]   pcTarget;
    logic              pcClear;
    logic              brightLoad;
    logic [BR_W-1:0]   brightVal;
    logic              brightUp;
    logic              brightDown;
    logic              brightClear;
    logic              trigLoad;
    logic [MASK_W-1:0] trigMask;
    logic              trigClear;
  } strobeT;
endpackage

// File: rtl/ledSeqCtrl.sv
`timescale 1ns/1ps
module ledSeqCtrl
  import ledSeqPkg::*;
#(
  parameter int TRIG_N     = 3,
  parameter int FAST_UNIT  = 16,
  parameter int SLOW_UNIT  = 512,
  parameter int SEND_TICKS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [1:0]        modeIn,
  input  logic              execWr,
  input  logic [1:0]        execIn,
  input  logic [TRIG_N-1:0] trigIn,
  input  logic [CMD_W-1:0]  cmd,
  output strobeT            stb,
  output modeT              modeNow,
  output stateT             stateNow
);
  localparam int STEP_MAX = 63;
  localparam int CNT_W    = $clog2(STEP_MAX * SLOW_UNIT + 1);
  localparam int SEND_W   = $clog2(SEND_TICKS + 1);

  execT              execReg, execN, pendExec;
  logic              pendV;
  stateT             stateN;
  logic [CNT_W-1:0]  tickCnt, tickCntN, period;
  logic [6:0]        steps, stepsN;
  logic [SEND_W-1:0] sendCnt, sendN;
  logic [5:0]        loopCnt, loopN;
  logic [TRIG_N-1:0] seen, seenN, newSeen;
  logic              done, halt;

  // command fields
  logic              preF, signF, endRst;
  logic [5:0]        stepF, loopF;
  logic [6:0]        cntF;
  logic [1:0]        opF;
  logic [TRIG_N-1:0] waitM, sendM;

  assign preF   = cmd[14];
  assign stepF  = cmd[13:8];
  assign signF  = cmd[7];
  assign cntF   = cmd[6:0];
  assign opF    = cmd[14:13];
  assign endRst = cmd[12];
  assign waitM  = cmd[6 +: TRIG_N];
  assign sendM  = cmd[0 +: TRIG_N];
  assign loopF  = cmd[9:4];
  assign period = CNT_W'(stepF) * (preF ? CNT_W'(SLOW_UNIT) : CNT_W'(FAST_UNIT));
  assign newSeen = seen | trigIn;

  always_comb begin
    stb      = '0;
    stateN   = stateNow;
    tickCntN = tickCnt;
    stepsN   = steps;
    sendN    = sendCnt;
    seenN    = seen;
    loopN    = loopCnt;
    execN    = execReg;
    done     = 1'b0;
    halt     = 1'b0;
    if (tick) begin
      if (pendV) begin
        execN         = pendExec;
        stateN        = ST_IDLE;
        stb.trigClear = 1'b1;
        loopN         = '0;
        if (pendExec == EX_RUN0) stb.pcClear = 1'b1;
      end else if (modeNow != MODE_RUN) begin
        stateN        = ST_IDLE;
        stb.trigClear = 1'b1;
      end else if (execReg != EX_HOLD) begin
        case (stateNow)
          ST_IDLE: begin
            if (!cmd[15]) begin
              if (stepF == '0) begin
                stb.brightLoad = 1'b1;
                stb.brightVal  = cmd[7:0];
                stb.pcInc      = 1'b1;
                done           = 1'b1;
              end else begin
                stateN   = ST_RAMP;
                tickCntN = period - 1'b1;
                stepsN   = cntF;
              end
            end else begin
              case (opF)
                OP_END: begin
                  halt = 1'b1;
                  stb.pcClear = endRst;
                end
                OP_TRIG: begin
                  if (sendM != '0) begin
                    stb.trigLoad = 1'b1;
                    stb.trigMask = MASK_W'(sendM);
                    sendN        = SEND_W'(SEND_TICKS);
                    stateN       = ST_SEND;
                  end else if (waitM != '0) begin
                    seenN  = '0;
                    stateN = ST_WAIT;
                  end else begin
                    stb.pcInc = 1'b1;
                    done      = 1'b1;
                  end
                end
                OP_BRANCH: begin
                  if (loopCnt < loopF) begin
                    loopN        = loopCnt + 1'b1;
                    stb.pcJump   = 1'b1;
                    stb.pcTarget = cmd[PC_W-1:0];
                  end else begin
                    loopN     = '0;
                    stb.pcInc = 1'b1;
                  end
                  done = 1'b1;
                end
                default: begin
                  stb.pcInc = 1'b1;
                  done      = 1'b1;
                end
              endcase
            end
          end
          ST_RAMP: begin
            if (tickCnt == '0) begin
              if (steps != '0) begin
                stb.brightUp   = !signF;
                stb.brightDown = signF;
              end
              if (steps <= 7'd1) begin
                stb.pcInc = 1'b1;
                done      = 1'b1;
                stateN    = ST_IDLE;
              end else begin
                stepsN   = steps - 1'b1;
                tickCntN = period - 1'b1;
              end
            end else begin
              tickCntN = tickCnt - 1'b1;
            end
          end
          ST_SEND: begin
            if (sendCnt == SEND_W'(1)) begin
              stb.trigClear = 1'b1;
              if (waitM != '0) begin
                seenN  = '0;
                stateN = ST_WAIT;
              end else begin
                stb.pcInc = 1'b1;
                done      = 1'b1;
                stateN    = ST_IDLE;
              end
            end else begin
              sendN = sendCnt - 1'b1;
            end
          end
          default: begin
            if ((newSeen & waitM) == waitM) begin
              stb.pcInc = 1'b1;
              done      = 1'b1;
              stateN    = ST_IDLE;
            end else begin
              seenN = newSeen;
            end
          end
        endcase
      end
      if (done && execReg == EX_STEP) execN = EX_HOLD;
      if (halt) execN = EX_HOLD;
      if (modeT'(modeIn) == MODE_OFF) begin
        stb             = '0;
        stb.pcClear     = 1'b1;
        stb.brightClear = 1'b1;
        stb.trigClear   = 1'b1;
        stateN          = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeNow  <= MODE_OFF;
      execReg  <= EX_HOLD;
      pendExec <= EX_HOLD;
      pendV    <= 1'b0;
      stateNow <= ST_IDLE;
      tickCnt  <= '0;
      steps    <= '0;
      sendCnt  <= '0;
      loopCnt  <= '0;
      seen     <= '0;
    end else begin
      if (execWr) begin
        pendV    <= 1'b1;
        pendExec <= execT'(execIn);
      end else if (tick) begin
        pendV <= 1'b0;
      end
      if (tick) modeNow <= modeT'(modeIn);
      execReg  <= execN;
      stateNow <= stateN;
      tickCnt  <= tickCntN;
      steps    <= stepsN;
      sendCnt  <= sendN;
      loopCnt  <= loopN;
      seen     <= seenN;
    end
  end
endmodule

// File: rtl/ledSeqData.sv
`timescale 1ns/1ps
module ledSeqData
  import ledSeqPkg::*;
#(
  parameter int TRIG_N = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  strobeT            stb,
  input  modeT              modeNow,
  input  logic              memWrEn,
  input  logic [PC_W-1:0]   memAddr,
  input  logic [CMD_W-1:0]  memData,
  input  logic              pcWrEn,
  input  logic [PC_W-1:0]   pcWrData,
  input  logic [BR_W-1:0]   directPwm,
  output logic [CMD_W-1:0]  cmd,
  output logic [PC_W-1:0]   pc,
  output logic [BR_W-1:0]   brightHeld,
  output logic [BR_W-1:0]   brightOut,
  output logic [TRIG_N-1:0] trigOut
);
  logic [CMD_W-1:0] store [CMD_DEPTH];
  logic [PC_W-1:0]  pcPend;
  logic             pcPendV;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CMD_DEPTH; i++) store[i] <= '0;
    end else if (memWrEn && modeNow == MODE_LOAD) begin
      store[memAddr] <= memData;
    end
  end

  assign cmd = store[pc];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc      <= '0;
      pcPend  <= '0;
      pcPendV <= 1'b0;
    end else begin
      if (pcWrEn) begin
        pcPend  <= pcWrData;
        pcPendV <= 1'b1;
      end else if (tick) begin
        pcPendV <= 1'b0;
      end
      if (stb.pcClear)           pc <= '0;
      else if (tick && pcPendV)  pc <= pcPend;
      else if (stb.pcJump)       pc <= stb.pcTarget;
      else if (stb.pcInc)        pc <= pc + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      brightHeld <= '0;
      trigOut    <= '0;
    end else begin
      if (stb.brightClear)                         brightHeld <= '0;
      else if (stb.brightLoad)                     brightHeld <= stb.brightVal;
      else if (stb.brightUp && brightHeld != '1)   brightHeld <= brightHeld + 1'b1;
      else if (stb.brightDown && brightHeld != '0) brightHeld <= brightHeld - 1'b1;
      if (stb.trigClear)     trigOut <= '0;
      else if (stb.trigLoad) trigOut <= stb.trigMask[TRIG_N-1:0];
    end
  end

  assign brightOut = (modeNow == MODE_DIRECT) ? directPwm : brightHeld;
endmodule

// File: rtl/ledSeqEngine.sv
`timescale 1ns/1ps
module ledSeqEngine
  import ledSeqPkg::*;
#(
  parameter int TRIG_N     = 3,
  parameter int FAST_UNIT  = 16,
  parameter int SLOW_UNIT  = 512,
  parameter int SEND_TICKS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [1:0]        modeIn,
  input  logic              execWr,
  input  logic [1:0]        execIn,
  input  logic              memWrEn,
  input  logic [3:0]        memAddr,
  input  logic [15:0]       memData,
  input  logic              pcWrEn,
  input  logic [3:0]        pcWrData,
  input  logic [7:0]        directPwm,
  input  logic [TRIG_N-1:0] trigIn,
  output logic [7:0]        brightOut,
  output logic [3:0]        pcOut,
  output logic [TRIG_N-1:0] trigOut
);
  strobeT           stb;
  modeT             modeNow;
  stateT            stateNow;
  logic [CMD_W-1:0] cmd;
  logic [BR_W-1:0]  brightHeld;

  ledSeqCtrl #(
    .TRIG_N(TRIG_N), .FAST_UNIT(FAST_UNIT),
    .SLOW_UNIT(SLOW_UNIT), .SEND_TICKS(SEND_TICKS)
  ) ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .modeIn(modeIn),
    .execWr(execWr), .execIn(execIn), .trigIn(trigIn), .cmd(cmd),
    .stb(stb), .modeNow(modeNow), .stateNow(stateNow)
  );

  ledSeqData #(.TRIG_N(TRIG_N)) data (
    .clk(clk), .rstN(rstN), .tick(tick), .stb(stb), .modeNow(modeNow),
    .memWrEn(memWrEn), .memAddr(memAddr), .memData(memData),
    .pcWrEn(pcWrEn), .pcWrData(pcWrData), .directPwm(directPwm),
    .cmd(cmd), .pc(pcOut), .brightHeld(brightHeld),
    .brightOut(brightOut), .trigOut(trigOut)
  );
endmodule

// File: rtl/ledSeqEngine_chk.sv
`timescale 1ns/1ps
module ledSeqEngine_chk
  import ledSeqPkg::*;
#(
  parameter int TRIG_N = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic [1:0]        modeIn,
  input modeT              modeNow,
  input stateT             stateNow,
  input logic [7:0]        brightHeld,
  input logic [7:0]        brightOut,
  input logic [3:0]        pcOut,
  input logic [TRIG_N-1:0] trigOut
);
  // R2: disabled channel is dark with counter at zero
  p_off_dark_r2: assert property (@(posedge clk) disable iff (!rstN)
    (modeNow == MODE_OFF) |-> (brightOut == 8'd0 && pcOut == 4'd0));

  // R9: counter and trigger lines move only on tick edges
  p_tick_only_r9: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> ($stable(pcOut) && $stable(trigOut)));

  // R5: a ramp moves brightness by at most one LSB per edge
  p_ramp_lsb_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stateNow == ST_RAMP && !(tick && modeIn == 2'b11)) |=>
      (brightHeld == $past(brightHeld) ||
       brightHeld == $past(brightHeld) + 8'd1 ||
       brightHeld == $past(brightHeld) - 8'd1));

  // R7: trigger lines are driven only during a send
  p_send_only_r7: assert property (@(posedge clk) disable iff (!rstN)
    (trigOut != '0) |-> (stateNow == ST_SEND));
endmodule

bind ledSeqEngine ledSeqEngine_chk #(.TRIG_N(TRIG_N)) chk (
  .clk(clk), .rstN(rstN), .tick(tick), .modeIn(modeIn),
  .modeNow(modeNow), .stateNow(stateNow), .brightHeld(brightHeld),
  .brightOut(brightOut), .pcOut(pcOut), .trigOut(trigOut)
);

// File: tb/ledSeqEngine_test.sv
`timescale 1ns/1ps
module ledSeqEngine_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] modeIn = 2'b11;
  logic       execWr = 1'b0;
  logic [1:0] execIn = 2'b00;
  logic       memWrEn = 1'b0;
  logic [3:0] memAddr = '0;
  logic [15:0] memData = '0;
  logic       pcWrEn = 1'b0;
  logic [3:0] pcWrData = '0;
  logic [7:0] directPwm = '0;
  logic [2:0] trigIn = '0;
  logic [7:0] brightOut;
  logic [3:0] pcOut;
  logic [2:0] trigOut;

  int tests = 0;
  int failed = 0;
  int cyc = 0;
  bit finished = 1'b0;

  ledSeqEngine uut (
    .clk(clk), .rstN(rstN), .tick(tick), .modeIn(modeIn),
    .execWr(execWr), .execIn(execIn), .memWrEn(memWrEn),
    .memAddr(memAddr), .memData(memData), .pcWrEn(pcWrEn),
    .pcWrData(pcWrData), .directPwm(directPwm), .trigIn(trigIn),
    .brightOut(brightOut), .pcOut(pcOut), .trigOut(trigOut)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !finished) begin
      failed++;
      tests++;
      $display("FAIL watchdog actual %0d expected <150000 cycles", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  typedef struct packed {
    logic [15:0] cmd;
    logic [7:0]  expB;
    logic [3:0]  expPc;
    logic [15:0] ticks;
  } rowT;

  localparam rowT ROWS [8] = '{
    '{16'h0040, 8'h40, 4'd1, 16'd1},
    '{16'h0103, 8'h43, 4'd2, 16'd60},
    '{16'h0182, 8'h41, 4'd3, 16'd40},
    '{16'h00FE, 8'hFE, 4'd4, 16'd1},
    '{16'h0105, 8'hFF, 4'd5, 16'd100},
    '{16'h0001, 8'h01, 4'd6, 16'd1},
    '{16'h0184, 8'h00, 4'd7, 16'd80},
    '{16'h0200, 8'h00, 4'd8, 16'd40}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic wrExec(input logic [1:0] v);
    @(negedge clk) begin execWr = 1'b1; execIn = v; end
    @(negedge clk) execWr = 1'b0;
  endtask

  task automatic wrMem(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk) begin memWrEn = 1'b1; memAddr = a; memData = d; end
    @(negedge clk) memWrEn = 1'b0;
  endtask

  task automatic wrPc(input logic [3:0] v);
    @(negedge clk) begin pcWrEn = 1'b1; pcWrData = v; end
    @(negedge clk) pcWrEn = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 bright", brightOut, 0);
    check("R1 pc", pcOut, 0);
    check("R1 trig", trigOut, 0);

    // load the program
    modeIn = 2'b01; tk(1);
    for (int i = 0; i < 8; i++) wrMem(4'(i), ROWS[i].cmd);
    wrMem(4'd8, 16'hA005);   // send 101
    wrMem(4'd9, 16'hA0C0);   // wait 011
    wrMem(4'd10, 16'h0101);  // ramp +1, 16 ticks
    wrMem(4'd11, 16'hC02A);  // loop twice to 10
    wrMem(4'd12, 16'h9000);  // end, clear pc
    wrMem(4'd13, 16'h4181);  // slow ramp -1
    wrMem(4'd15, 16'h0077);  // set 0x77

    modeIn = 2'b10; tk(1);
    check("R2 run entry pc", pcOut, 0);

    // table walk in single-step mode (R5 ramps, R6 sets, R10 step)
    for (int r = 0; r < 8; r++) begin
      wrExec(2'b01);
      tk(1 + int'(ROWS[r].ticks));
      check("R5 R6 R10 table bright", brightOut, ROWS[r].expB);
      check("R5 R6 R10 table pc", pcOut, ROWS[r].expPc);
    end

    // R4: write outside load mode must be ignored
    wrMem(4'd0, 16'h0099);

    // R9 pc write waits for tick; R13 wrap
    wrPc(4'd15);
    check("R9 pc before tick", pcOut, 8);
    tk(1);
    check("R9 pc after tick", pcOut, 15);
    wrExec(2'b01); tk(2);
    check("R13 wrap pc", pcOut, 0);
    check("R13 wrap bright", brightOut, 8'h77);
    wrExec(2'b01); tk(2);
    check("R4 ignored write bright", brightOut, 8'h40);
    check("R4 ignored write pc", pcOut, 1);

    // R10 run-from-start, then hold
    wrPc(4'd5); tk(1);
    wrExec(2'b10); tk(1);
    check("R10 run0 pc clear", pcOut, 0);
    tk(1);
    check("R10 run0 first cmd", brightOut, 8'h40);
    wrExec(2'b00); tk(21);
    check("R10 hold pc", pcOut, 1);
    check("R10 hold bright", brightOut, 8'h40);

    // R5 slow prescale timing
    wrPc(4'd13); tk(1);
    wrExec(2'b01); tk(2);
    tk(511);
    check("R5 slow before step", brightOut, 8'h40);
    tk(1);
    check("R5 slow step", brightOut, 8'h3F);
    check("R5 slow pc", pcOut, 14);

    // R7 send, R8 wait
    wrPc(4'd8); tk(1);
    wrExec(2'b11); tk(2);
    check("R7 send start", trigOut, 3'b101);
    tk(15);
    check("R7 send held", trigOut, 3'b101);
    check("R7 pc during send", pcOut, 8);
    tk(1);
    check("R7 send drop", trigOut, 3'b000);
    check("R7 pc after send", pcOut, 9);
    tk(4);
    check("R8 stalled", pcOut, 9);
    trigIn = 3'b001; tk(1); trigIn = 3'b000;
    check("R8 partial", pcOut, 9);
    tk(2);
    check("R8 still partial", pcOut, 9);
    trigIn = 3'b010; tk(1); trigIn = 3'b000;
    check("R8 released", pcOut, 10);

    // R11 loop, R12 end
    tk(200);
    check("R11 loop bright", brightOut, 8'h42);
    check("R12 end pc", pcOut, 0);
    tk(30);
    check("R12 halted bright", brightOut, 8'h42);
    check("R12 halted pc", pcOut, 0);

    // R3 direct mode
    modeIn = 2'b00; directPwm = 8'h5A;
    @(negedge clk);
    check("R9 mode waits tick", brightOut, 8'h42);
    tk(1);
    check("R3 direct", brightOut, 8'h5A);
    directPwm = 8'h33;
    @(negedge clk);
    check("R3 direct follow", brightOut, 8'h33);

    // R2 disabled
    wrPc(4'd6); tk(1);
    check("R9 pc write direct", pcOut, 6);
    modeIn = 2'b11; tk(1);
    check("R2 off bright", brightOut, 0);
    check("R2 off pc", pcOut, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule